// File: doc/BRIEF.md
# Shared Task Queue with Completion Barrier

This block is a work pool shared by a fixed group of cores. Any core can add work by enqueuing a descriptor, either a single task or a group of tasks that share a base value. Any core can also ask for work. A core that asks while the pool is dry is parked in a waiting line. When work arrives, it is handed out to the parked cores in the order they joined that line.

No separate barrier instruction is needed. The block itself notices when every participating core is parked and no work is left anywhere. At that point it declares the current interval over and pulses a barrier indication to all cores at once. It then starts the next interval empty. Because of this, cores may create new work at any point during an interval; the interval ends only when nothing remains to be done.

The pool keeps a fixed number of descriptor slots. An enqueue that finds every slot occupied is refused with a full indication, and the requester may try again later. Each request line is a level. Enqueue results come back in the same cycle the request is presented. Dequeued descriptors come back on registered per-core outputs.

Top module: `task_queue_barrier`

## Requirements
- R1: While reset is active and after it is released, `q_state` reads 0 (empty) and `enq_ack`, `enq_full`, `deq_valid` and `barrier` are all zero.
- R2: When several cores request an enqueue in one cycle, only the lowest-numbered requester is answered. `enq_ack` is raised for it in that same cycle, and an accepted enqueue into an empty pool changes `q_state` from 0 (empty) to 1 (tasks available) on the next cycle.
- R3: Once all DEPTH slots are occupied, `q_state` reads 2 (full). A further enqueue gets `enq_full` instead of `enq_ack`, and its descriptor never reaches any dequeuer.
- R4: While tasks are available, a core that raises `deq_req` sees `deq_valid` with a descriptor on its lane after exactly two rising edges: one edge joins it to the waiting line and the next serves it.
- R5: While the pool is empty, a requesting core gets no `deq_valid`. The cycle after an enqueue is accepted, the parked core at the head of the line receives that task.
- R6: Parked cores are served in the order they arrived. Cores that arrive in the same cycle join the line one per cycle, lowest-numbered first.
- R7: An enqueue with `enq_extra` = k occupies one slot and yields k+1 tasks. Successive dequeues receive base, base+1, … base+k, wrapping modulo 2^DESC_W.
- R8: When all NCORE cores are parked and no task is held, `q_state` reads 3 (completed) for exactly one cycle, with `barrier` high on every lane. The block then returns to 0 (empty) with no core parked.
- R9: During the completed cycle, enqueue and dequeue requests are ignored: no `enq_ack` or `enq_full` is given, no descriptor is stored, and no core joins the waiting line.
- R10: Slots are handed out in the order in which their enqueues were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_req | input | NCORE | Per-core enqueue request (level) |
| enq_base | input | NCORE*DESC_W | Per-core base descriptor |
| enq_extra | input | NCORE*CNT_W | Per-core group size minus one |
| enq_ack | output | NCORE | Enqueue accepted this cycle |
| enq_full | output | NCORE | Enqueue refused, pool full |
| deq_req | input | NCORE | Per-core dequeue request (level, held until served or barrier) |
| deq_valid | output | NCORE | Descriptor delivered on this lane |
| deq_task | output | NCORE*DESC_W | Per-core delivered descriptor |
| barrier | output | NCORE | Interval-complete indication, all lanes together |
| q_state | output | 2 | 0 empty, 1 tasks available, 2 full, 3 completed |

## Verification
The first pattern is a vector sequence that mixes single and group enqueues from different cores with dequeues. It fills the pool to its limit, refuses an enqueue, drains, and refills. This separates slot accounting from task accounting and exposes any wrong order or lost refusal. The second pattern is a set of directed cases. Staggered parked arrivals followed by one group enqueue show that the line is served in arrival order rather than core order. Simultaneous enqueues show the priority. A base at the top of the descriptor range shows wraparound. Finally, all cores park so that the barrier fires, with an enqueue presented during the completed cycle; a dequeue afterwards proves that enqueue left nothing behind.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    TQ_EMPTY = 2'd0,
    TQ_AVAIL = 2'd1,
    TQ_FULL  = 2'd2,
    TQ_DONE  = 2'd3
  } tq_state_e;
endpackage

// File: rtl/tq_first_pick.sv
module tq_first_pick #(
  parameter int W   = 4,
  parameter int IDW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]   req,
  output logic [IDW-1:0] idx,
  output logic           any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IDW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/tq_desc_fifo.sv
module tq_desc_fifo #(
  parameter int DEPTH  = 8,
  parameter int DESC_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DESC_W-1:0] push_base,
  input  logic [CNT_W-1:0]  push_extra,
  input  logic              take,
  output logic [DESC_W-1:0] head_task,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DESC_W-1:0] base_mem  [DEPTH];
  logic [CNT_W-1:0]  extra_mem [DEPTH];
  logic [PW-1:0]     wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [CNT_W-1:0]  off_q, off_n;
  logic              last_of_entry, pop_entry;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full          = (cnt_q == CW'(DEPTH));
  assign empty         = (cnt_q == '0);
  assign last_of_entry = (off_q == extra_mem[rd_q]);
  assign pop_entry     = take && last_of_entry;
  assign head_task     = base_mem[rd_q] + DESC_W'(off_q);

  always_comb begin
    wr_n  = push ? step(wr_q) : wr_q;
    rd_n  = pop_entry ? step(rd_q) : rd_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop_entry);
    off_n = off_q;
    if (take) off_n = last_of_entry ? '0 : off_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      off_q <= off_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      base_mem[wr_q]  <= push_base;
      extra_mem[wr_q] <= push_extra;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_push_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_take_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !empty);
  p_group_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last_of_entry) |=> (head_task == $past(head_task) + DESC_W'(1)));
endmodule

// File: rtl/tq_waiter_list.sv
module tq_waiter_list #(
  parameter int NCORE = 4,
  parameter int IDW   = (NCORE > 1) ? $clog2(NCORE) : 1,
  parameter int CW    = $clog2(NCORE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [IDW-1:0]   push_id,
  input  logic             pop,
  output logic [IDW-1:0]   head_id,
  output logic [CW-1:0]    cnt,
  output logic [NCORE-1:0] parked
);
  logic [IDW-1:0]   id_mem [NCORE];
  logic [IDW-1:0]   wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [NCORE-1:0] park_q, park_n;

  function automatic logic [IDW-1:0] step(input logic [IDW-1:0] p);
    return (p == IDW'(NCORE - 1)) ? '0 : p + IDW'(1);
  endfunction

  assign head_id = id_mem[rd_q];
  assign cnt     = cnt_q;
  assign parked  = park_q;

  always_comb begin
    wr_n   = wr_q;
    rd_n   = rd_q;
    cnt_n  = cnt_q;
    park_n = park_q;
    if (clear) begin
      wr_n   = '0;
      rd_n   = '0;
      cnt_n  = '0;
      park_n = '0;
    end else begin
      if (push) begin
        park_n[push_id] = 1'b1;
        wr_n            = step(wr_q);
      end
      if (pop) begin
        park_n[head_id] = 1'b0;
        rd_n            = step(rd_q);
      end
      cnt_n = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      park_q <= '0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      park_q <= park_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) id_mem[wr_q] <= push_id;
  end

  p_push_unparked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !park_q[push_id]);
  p_line_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NCORE));
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  p_count_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(park_q) == int'(cnt_q));
endmodule

// File: rtl/task_queue_barrier.sv
module task_queue_barrier
  import tq_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int DEPTH  = 8,
  parameter int DESC_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORE-1:0]        enq_req,
  input  logic [NCORE*DESC_W-1:0] enq_base,
  input  logic [NCORE*CNT_W-1:0]  enq_extra,
  output logic [NCORE-1:0]        enq_ack,
  output logic [NCORE-1:0]        enq_full,
  input  logic [NCORE-1:0]        deq_req,
  output logic [NCORE-1:0]        deq_valid,
  output logic [NCORE*DESC_W-1:0] deq_task,
  output logic [NCORE-1:0]        barrier,
  output logic [1:0]              q_state
);
  localparam int IDW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int WCW = $clog2(NCORE + 1);

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [DESC_W-1:0] base_arr  [NCORE];
  logic [CNT_W-1:0]  extra_arr [NCORE];
  logic [DESC_W-1:0] task_q    [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_lane
    assign base_arr[c]  = enq_base[c*DESC_W +: DESC_W];
    assign extra_arr[c] = enq_extra[c*CNT_W +: CNT_W];
    assign deq_task[c*DESC_W +: DESC_W] = task_q[c];
  end

  logic [IDW-1:0]   enq_idx, reg_idx, head_id;
  logic             enq_any, reg_any;
  logic [WCW-1:0]   wl_cnt;
  logic [NCORE-1:0] parked;
  logic [DESC_W-1:0] head_task;
  logic             fifo_full, fifo_empty;
  logic             done_q, done_n;
  logic             enq_take, enq_refuse, wl_push, serve, finish;
  logic [NCORE-1:0] enq_grant;
  logic [NCORE-1:0] valid_q, valid_n;

  tq_first_pick #(.W(NCORE), .IDW(IDW)) u_enq_pick (
    .req (enq_req),
    .idx (enq_idx),
    .any (enq_any)
  );

  tq_first_pick #(.W(NCORE), .IDW(IDW)) u_reg_pick (
    .req (deq_req & ~parked),
    .idx (reg_idx),
    .any (reg_any)
  );

  tq_desc_fifo #(.DEPTH(DEPTH), .DESC_W(DESC_W), .CNT_W(CNT_W)) u_fifo (
    .clk        (clk),
    .rst_n      (srst_n),
    .push       (enq_take),
    .push_base  (base_arr[enq_idx]),
    .push_extra (extra_arr[enq_idx]),
    .take       (serve),
    .head_task  (head_task),
    .full       (fifo_full),
    .empty      (fifo_empty)
  );

  tq_waiter_list #(.NCORE(NCORE), .IDW(IDW), .CW(WCW)) u_line (
    .clk     (clk),
    .rst_n   (srst_n),
    .clear   (done_q),
    .push    (wl_push),
    .push_id (reg_idx),
    .pop     (serve),
    .head_id (head_id),
    .cnt     (wl_cnt),
    .parked  (parked)
  );

  always_comb begin
    enq_grant  = NCORE'(1) << enq_idx;
    enq_take   = enq_any && !done_q && !fifo_full;
    enq_refuse = enq_any && !done_q && fifo_full;
    wl_push    = reg_any && !done_q;
    serve      = (wl_cnt != '0) && !fifo_empty && !done_q;
    finish     = !done_q && (wl_cnt == WCW'(NCORE)) && fifo_empty && !enq_take;
    done_n     = finish;
    valid_n    = serve ? (NCORE'(1) << head_id) : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q  <= 1'b0;
      valid_q <= '0;
    end else begin
      done_q  <= done_n;
      valid_q <= valid_n;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_task
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)                          task_q[c] <= '0;
      else if (serve && head_id == IDW'(c)) task_q[c] <= head_task;
    end
  end

  assign enq_ack   = enq_take   ? enq_grant : '0;
  assign enq_full  = enq_refuse ? enq_grant : '0;
  assign deq_valid = valid_q;
  assign barrier   = {NCORE{done_q}};
  assign q_state   = done_q ? TQ_DONE : fifo_full ? TQ_FULL :
                     fifo_empty ? TQ_EMPTY : TQ_AVAIL;

  p_enq_onehot_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(enq_ack | enq_full));
  p_refuse_only_full_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (enq_full != '0) |-> (q_state == TQ_FULL));
  p_deq_onehot_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(deq_valid));
  p_empty_no_serve_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (q_state == TQ_EMPTY) |=> (deq_valid == '0));
  p_barrier_all_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (barrier != '0) |-> (&barrier));
  p_barrier_once_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (barrier != '0) |=> (barrier == '0 && q_state == TQ_EMPTY && parked == '0));
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (q_state == TQ_DONE) |-> (enq_ack == '0 && enq_full == '0));
endmodule

// File: tb/task_queue_barrier_bench.sv
module task_queue_barrier_bench;
  localparam int NC = 4;
  localparam int DW = 16;
  localparam int XW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NC-1:0]     enq_req, enq_ack, enq_full, deq_req, deq_valid, barrier;
  logic [NC*DW-1:0]  enq_base, deq_task;
  logic [NC*XW-1:0]  enq_extra;
  logic [1:0]        q_state;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  task_queue_barrier #(.NCORE(NC), .DEPTH(4), .DESC_W(DW), .CNT_W(XW)) u_task_queue_barrier (
    .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .enq_base(enq_base),
    .enq_extra(enq_extra), .enq_ack(enq_ack), .enq_full(enq_full),
    .deq_req(deq_req), .deq_valid(deq_valid), .deq_task(deq_task),
    .barrier(barrier), .q_state(q_state)
  );

  typedef struct packed {
    logic        is_deq;
    logic [1:0]  core;
    logic [15:0] base;
    logic [3:0]  extra;
    logic        exp_ack;
    logic [15:0] exp_desc;
    logic [1:0]  exp_st;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 2'd1, 16'h0100, 4'd0, 1'b1, 16'h0000, 2'd1},
    '{1'b0, 2'd2, 16'h0200, 4'd2, 1'b1, 16'h0000, 2'd1},
    '{1'b0, 2'd0, 16'h0300, 4'd0, 1'b1, 16'h0000, 2'd1},
    '{1'b0, 2'd3, 16'h0400, 4'd1, 1'b1, 16'h0000, 2'd2},
    '{1'b0, 2'd0, 16'h0500, 4'd0, 1'b0, 16'h0000, 2'd2},
    '{1'b1, 2'd0, 16'h0000, 4'd0, 1'b0, 16'h0100, 2'd1},
    '{1'b1, 2'd1, 16'h0000, 4'd0, 1'b0, 16'h0200, 2'd1},
    '{1'b1, 2'd2, 16'h0000, 4'd0, 1'b0, 16'h0201, 2'd1},
    '{1'b0, 2'd1, 16'h0600, 4'd0, 1'b1, 16'h0000, 2'd2},
    '{1'b0, 2'd2, 16'h0700, 4'd0, 1'b0, 16'h0000, 2'd2},
    '{1'b1, 2'd3, 16'h0000, 4'd0, 1'b0, 16'h0202, 2'd1},
    '{1'b1, 2'd0, 16'h0000, 4'd0, 1'b0, 16'h0300, 2'd1},
    '{1'b1, 2'd1, 16'h0000, 4'd0, 1'b0, 16'h0400, 2'd1},
    '{1'b1, 2'd2, 16'h0000, 4'd0, 1'b0, 16'h0401, 2'd1},
    '{1'b1, 2'd3, 16'h0000, 4'd0, 1'b0, 16'h0600, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_enq(input int c, input logic [15:0] b, input logic [3:0] x,
                        output logic ack, output logic ful);
    @(negedge clk);
    enq_req = '0;
    enq_req[c] = 1'b1;
    enq_base[c*DW +: DW] = b;
    enq_extra[c*XW +: XW] = x;
    #1;
    ack = enq_ack[c];
    ful = enq_full[c];
    @(negedge clk);
    enq_req = '0;
  endtask

  task automatic do_deq(input int c, output logic [15:0] d, output int lat);
    bit got = 0;
    @(negedge clk);
    deq_req[c] = 1'b1;
    lat = 0;
    d = '0;
    while (!got && lat < 30) begin
      @(negedge clk);
      lat++;
      if (deq_valid[c]) begin
        d = deq_task[c*DW +: DW];
        got = 1;
      end
    end
    deq_req[c] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        a, f;
    logic [15:0] d;
    int          lat;
    rst_n = 1'b0;
    enq_req = '0; deq_req = '0; enq_base = '0; enq_extra = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset state", {30'd0, q_state}, 32'd0);
    chk("R1 reset outputs", {enq_ack, enq_full, deq_valid, barrier}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 released state", {30'd0, q_state}, 32'd0);
    chk("R1 released outputs", {enq_ack, enq_full, deq_valid, barrier}, 32'd0);

    // vector table: R2 R3 R4 R7 R10
    for (int i = 0; i < 15; i++) begin
      if (!VEC[i].is_deq) begin
        do_enq(int'(VEC[i].core), VEC[i].base, VEC[i].extra, a, f);
        chk($sformatf("R2/R3 vec %0d ack", i), {31'd0, a}, {31'd0, VEC[i].exp_ack});
        chk($sformatf("R3 vec %0d full", i), {31'd0, f}, {31'd0, !VEC[i].exp_ack});
      end else begin
        do_deq(int'(VEC[i].core), d, lat);
        chk($sformatf("R7/R10 vec %0d desc", i), {16'd0, d}, {16'd0, VEC[i].exp_desc});
        chk($sformatf("R4 vec %0d latency", i), lat, 32'd2);
      end
      chk($sformatf("R2/R3 vec %0d state", i), {30'd0, q_state}, {30'd0, VEC[i].exp_st});
    end

    // R2 priority among simultaneous enqueues
    @(negedge clk);
    enq_req = 4'b0110;
    enq_base[1*DW +: DW] = 16'h00D1; enq_extra[1*XW +: XW] = '0;
    enq_base[2*DW +: DW] = 16'h00D2; enq_extra[2*XW +: XW] = '0;
    #1 chk("R2 lowest index wins", {28'd0, enq_ack | enq_full}, 32'b0010);
    @(negedge clk);
    enq_req = 4'b0100;
    #1 chk("R2 loser served next", {28'd0, enq_ack}, 32'b0100);
    @(negedge clk);
    enq_req = '0;
    do_deq(0, d, lat);
    chk("R10 first accepted first out", {16'd0, d}, 32'h00D1);
    do_deq(3, d, lat);
    chk("R10 second accepted", {16'd0, d}, 32'h00D2);

    // R7 wraparound
    do_enq(0, 16'hFFFF, 4'd1, a, f);
    do_deq(1, d, lat);
    chk("R7 wrap first", {16'd0, d}, 32'hFFFF);
    do_deq(1, d, lat);
    chk("R7 wrap second", {16'd0, d}, 32'h0000);

    // R5 blocking on empty
    @(negedge clk);
    deq_req[2] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5 parked no data", {28'd0, deq_valid}, 32'd0);
      chk("R8 no barrier with one parked", {28'd0, barrier}, 32'd0);
    end
    do_enq(0, 16'h00A0, 4'd0, a, f);
    @(negedge clk);
    chk("R5 parked core released", {28'd0, deq_valid}, 32'b0100);
    chk("R5 parked core task", {16'd0, deq_task[2*DW +: DW]}, 32'h00A0);
    deq_req[2] = 1'b0;

    // R6 arrival order: 1 and 3 together, then 0
    @(negedge clk);
    deq_req[3] = 1'b1; deq_req[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    deq_req[0] = 1'b1;
    @(negedge clk);
    do_enq(2, 16'h00B0, 4'd2, a, f);
    @(negedge clk);
    chk("R6 first served core1", {28'd0, deq_valid}, 32'b0010);
    chk("R6/R7 core1 task", {16'd0, deq_task[1*DW +: DW]}, 32'h00B0);
    deq_req[1] = 1'b0;
    @(negedge clk);
    chk("R6 second served core3", {28'd0, deq_valid}, 32'b1000);
    chk("R6/R7 core3 task", {16'd0, deq_task[3*DW +: DW]}, 32'h00B1);
    deq_req[3] = 1'b0;
    @(negedge clk);
    chk("R6 third served core0", {28'd0, deq_valid}, 32'b0001);
    chk("R6/R7 core0 task", {16'd0, deq_task[0*DW +: DW]}, 32'h00B2);
    deq_req[0] = 1'b0;

    // R8 barrier and R9 ignore during completed cycle
    @(negedge clk);
    deq_req = 4'b1111;
    repeat (4) @(negedge clk);
    chk("R8 no barrier before last joins", {28'd0, barrier}, 32'd0);
    @(negedge clk);
    chk("R8 barrier all lanes", {28'd0, barrier}, 32'hF);
    chk("R8 completed state", {30'd0, q_state}, 32'd3);
    enq_req = 4'b0001;
    enq_base[0*DW +: DW] = 16'h0EEE; enq_extra[0*XW +: XW] = '0;
    #1 chk("R9 no answer when completed", {24'd0, enq_ack, enq_full}, 32'd0);
    enq_req = '0;
    deq_req = '0;
    @(negedge clk);
    chk("R8 back to empty", {30'd0, q_state}, 32'd0);
    chk("R8 barrier single cycle", {28'd0, barrier}, 32'd0);
    do_enq(1, 16'h00C0, 4'd0, a, f);
    do_deq(2, d, lat);
    chk("R9 ignored enqueue left nothing", {16'd0, d}, 32'h00C0);
    chk("R8 fresh interval latency", lat, 32'd2);
    chk("R9 pool empty afterwards", {30'd0, q_state}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule